// File: doc/BRIEF.md
# Control Setup Transaction Issuer

This block starts a USB host control transfer by sending its setup stage. Software loads the eight-byte standard request into four 16-bit request registers. It places the target device address in a pipe configuration register and then writes the start bit. The block then streams two packets to the packet layer, byte by byte. The first is a setup token. The second is a data packet that always carries the DATA0 PID and holds the request. After that, the block waits a bounded number of cycles for the device's handshake.

When the handshake arrives, or when the wait runs out, the block clears the start bit and records the outcome in sticky interrupt flags. A positive acknowledge also arms the pipe's data toggle, so the first data-stage packet goes out as DATA1. While a request is in flight, the request registers are frozen, and any attempt to write them is flagged as an error.

Top module: `setup_issuer`

## Requirements
- R1: After reset every register reads 0, `txValid` is 0 and `irq` is 0.
- R2: Writing a 1 to bit 0 of register 5 sets the start bit, and register 5 reads 1 while the request runs. The block clears the bit to 0 when it finishes.
- R3: The token packet is three bytes. The first is 0x2D, marked `txFirst`. The second is `{1'b0, device address}`, where the address is taken from bits 6:0 of register 4 when the request starts. The third is 0x00, marked `txLast`.
- R4: The data packet is nine bytes. The first is 0x2D's counterpart for data, 0xC3 (DATA0), marked `txFirst`, whatever the value of the toggle bit (register 4 bit 8). Next come the request type and request code (register 0, low byte then high byte). Then come value, index and length (registers 1, 2 and 3), each low byte first. The last byte is marked `txLast`.
- R5: A byte advances only in a cycle where `txValid` and `txReady` are both high. While the pair is stalled, `txByte` holds.
- R6: A handshake byte 0xD2 (ACK) sets register 6 bit 0 and sets the toggle bit (register 4 bit 8) to 1.
- R7: Any other handshake byte sets register 6 bit 1 and leaves the toggle bit unchanged.
- R8: The response window is TIMEOUT_CYC cycles, counted from the cycle after the last data byte is accepted. A handshake in the last cycle of the window still counts. If nothing arrives within the window, register 6 bit 1 is set.
- R9: A write to registers 0 to 3 while the start bit is 1 leaves them unchanged and sets register 6 bit 2.
- R10: Register 6 flags stay set until a 1 is written to them, and `irq` is the OR of the three flags.
- R11: A handshake byte that arrives when no response is awaited changes no flag and no toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register write address |
| regWrData | input | 16 | Register write data |
| regRdAddr | input | 3 | Register read address |
| regRdData | output | 16 | Register read data (combinational) |
| txValid | output | 1 | Byte offered to the packet layer |
| txReady | input | 1 | Packet layer accepts the byte |
| txByte | output | 8 | Byte being offered |
| txFirst | output | 1 | Byte is the PID of a packet |
| txLast | output | 1 | Byte ends a packet |
| rxValid | input | 1 | Handshake PID byte present |
| rxPid | input | 8 | Handshake PID byte |
| irq | output | 1 | Any interrupt flag set |

## Verification
A sequencer index that is wrong shows up at once in the byte stream. The scoreboard compares every accepted byte, together with its packet markers, against the request that was loaded, so the first misplaced byte is caught in the cycle it is accepted. A fault in the response window or in the outcome decode shows up a few cycles after the handshake. It appears as the wrong flag in register 6, a wrong toggle bit, or a start bit that does not clear. Both edges of the window, its last cycle and the cycle after it, are driven on purpose.

// File: rtl/setup_pkg.sv
package setup_pkg;
  localparam int REQ_REGS   = 4;
  localparam int PAYLOAD    = 2 * REQ_REGS;
  localparam int TOKEN_LEN  = 3;
  localparam int SEQ_LEN    = TOKEN_LEN + 1 + PAYLOAD;
  localparam int IDX_W      = $clog2(SEQ_LEN);

  localparam logic [7:0] PID_SETUP = 8'h2D;
  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_ACK   = 8'hD2;

  localparam logic [2:0] ADDR_PIPE = 3'd4;
  localparam logic [2:0] ADDR_CTRL = 3'd5;
  localparam logic [2:0] ADDR_STAT = 3'd6;

  typedef struct packed {
    logic             start;
    logic             finish;
    logic             ackSeen;
    logic [IDX_W-1:0] byteIdx;
  } seqCtl_t;
endpackage

// File: rtl/setup_datapath.sv
module setup_datapath
  import setup_pkg::*;
#(
  parameter int DEV_W = 7
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic [2:0]    regAddr,
  input  logic [15:0]   regWrData,
  input  logic [2:0]    regRdAddr,
  output logic [15:0]   regRdData,
  input  seqCtl_t       ctl,
  output logic          goBit,
  output logic [7:0]    txByte,
  output logic [2:0]    intStat
);
  localparam int OFF = TOKEN_LEN + 1;

  logic [REQ_REGS-1:0][15:0] reqReg;
  logic [PAYLOAD-1:0][7:0]   payload;
  logic [DEV_W-1:0]          devAddr;
  logic [DEV_W-1:0]          devLatch;
  logic                      toggleBit;
  logic                      reqWr;
  logic                      errEvt;
  logic [2:0]                setMask;
  logic [2:0]                clrMask;
  logic [IDX_W-1:0]          payIdx;

  assign reqWr  = regWrEn && (regAddr < 3'(REQ_REGS));
  assign errEvt = reqWr && goBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqReg <= '0;
    end else if (reqWr && !goBit) begin
      for (int k = 0; k < REQ_REGS; k++) begin
        if (regAddr == 3'(k)) reqReg[k] <= regWrData;
      end
    end
  end

  generate
    for (genvar g = 0; g < REQ_REGS; g++) begin : g_pay
      assign payload[2*g]   = reqReg[g][7:0];
      assign payload[2*g+1] = reqReg[g][15:8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devAddr   <= '0;
      devLatch  <= '0;
      toggleBit <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_PIPE) begin
        devAddr   <= regWrData[DEV_W-1:0];
        toggleBit <= regWrData[8];
      end
      if (ctl.finish && ctl.ackSeen) toggleBit <= 1'b1;
      if (ctl.start) devLatch <= devAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goBit <= 1'b0;
    end else if (ctl.finish) begin
      goBit <= 1'b0;
    end else if (regWrEn && regAddr == ADDR_CTRL && regWrData[0]) begin
      goBit <= 1'b1;
    end
  end

  assign setMask = {errEvt, ctl.finish && !ctl.ackSeen, ctl.finish && ctl.ackSeen};
  assign clrMask = (regWrEn && regAddr == ADDR_STAT) ? regWrData[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rstN) intStat <= '0;
    else       intStat <= (intStat & ~clrMask) | setMask;
  end

  assign payIdx = ctl.byteIdx - IDX_W'(OFF);

  always_comb begin
    case (ctl.byteIdx)
      IDX_W'(0): txByte = PID_SETUP;
      IDX_W'(1): txByte = 8'({1'b0, devLatch});
      IDX_W'(2): txByte = 8'h00;
      IDX_W'(3): txByte = PID_DATA0;
      default:   txByte = payload[payIdx[$clog2(PAYLOAD)-1:0]];
    endcase
  end

  always_comb begin
    regRdData = '0;
    case (regRdAddr)
      ADDR_PIPE: begin
        regRdData[DEV_W-1:0] = devAddr;
        regRdData[8]         = toggleBit;
      end
      ADDR_CTRL: regRdData[0]   = goBit;
      ADDR_STAT: regRdData[2:0] = intStat;
      default: begin
        for (int k = 0; k < REQ_REGS; k++) begin
          if (regRdAddr == 3'(k)) regRdData = reqReg[k];
        end
      end
    endcase
  end
endmodule

// File: rtl/setup_control.sv
module setup_control
  import setup_pkg::*;
#(
  parameter int TIMEOUT_CYC = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       goBit,
  input  logic       txReady,
  input  logic       rxValid,
  input  logic [7:0] rxPid,
  output logic       txValid,
  output logic       txFirst,
  output logic       txLast,
  output seqCtl_t    ctl
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} state_t;

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic [TW-1:0]    timer;

  always_comb begin
    ctl         = '0;
    ctl.byteIdx = idx;
    ctl.start   = (state == ST_IDLE) && goBit;
    if (state == ST_WAIT) begin
      if (rxValid) begin
        ctl.finish  = 1'b1;
        ctl.ackSeen = (rxPid == PID_ACK);
      end else if (timer == TW'(TIMEOUT_CYC - 1)) begin
        ctl.finish = 1'b1;
      end
    end
  end

  assign txValid = (state == ST_SEND);
  assign txFirst = txValid && (idx == IDX_W'(0) || idx == IDX_W'(TOKEN_LEN));
  assign txLast  = txValid && (idx == IDX_W'(TOKEN_LEN - 1) || idx == IDX_W'(SEQ_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      timer <= '0;
    end else begin
      case (state)
        ST_IDLE: if (goBit) begin
          state <= ST_SEND;
          idx   <= '0;
        end
        ST_SEND: if (txReady) begin
          if (idx == IDX_W'(SEQ_LEN - 1)) begin
            state <= ST_WAIT;
            timer <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_WAIT: begin
          if (ctl.finish) state <= ST_IDLE;
          else            timer <= timer + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/setup_issuer.sv
module setup_issuer
  import setup_pkg::*;
#(
  parameter int DEV_W       = 7,
  parameter int TIMEOUT_CYC = 18
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWrData,
  input  logic [2:0]  regRdAddr,
  output logic [15:0] regRdData,
  output logic        txValid,
  input  logic        txReady,
  output logic [7:0]  txByte,
  output logic        txFirst,
  output logic        txLast,
  input  logic        rxValid,
  input  logic [7:0]  rxPid,
  output logic        irq
);
  seqCtl_t    ctl;
  logic       goBit;
  logic [2:0] intStat;

  setup_datapath #(.DEV_W(DEV_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .ctl(ctl), .goBit(goBit), .txByte(txByte), .intStat(intStat)
  );

  setup_control #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctl (
    .clk(clk), .rstN(rstN), .goBit(goBit), .txReady(txReady),
    .rxValid(rxValid), .rxPid(rxPid), .txValid(txValid),
    .txFirst(txFirst), .txLast(txLast), .ctl(ctl)
  );

  assign irq = |intStat;
endmodule

// File: rtl/setup_issuer_chk.sv
module setup_issuer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       txValid,
  input logic       txReady,
  input logic [7:0] txByte,
  input logic       txFirst,
  input logic       txLast,
  input logic       regWrEn,
  input logic [2:0] regAddr,
  input logic       goBit,
  input logic [2:0] intStat,
  input logic       irq
);
  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txByte) && $stable(txFirst) && $stable(txLast));

  // R4
  pid_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    txFirst |-> (txByte == 8'h2D || txByte == 8'hC3));

  // R3
  marker_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    txFirst |-> !txLast);

  // R2
  busy_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> goBit);

  // R9
  lock_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    goBit && regWrEn && regAddr < 3'd4 |=> intStat[2]);

  // R10
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq && !(regWrEn && regAddr == 3'd6) |=> irq);
endmodule

bind setup_issuer setup_issuer_chk u_chk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .txByte(txByte), .txFirst(txFirst), .txLast(txLast), .regWrEn(regWrEn),
  .regAddr(regAddr), .goBit(goBit), .intStat(intStat), .irq(irq)
);

// File: tb/tb_setup_issuer.sv
module tb_setup_issuer;
  localparam int TOUT = 18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [2:0]  regRdAddr = '0;
  logic [15:0] regRdData;
  logic        txValid;
  logic        txReady = 1'b1;
  logic [7:0]  txByte;
  logic        txFirst;
  logic        txLast;
  logic        rxValid = 1'b0;
  logic [7:0]  rxPid = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int acceptCnt = 0;
  int cyc = 0;
  bit stallMode = 0;
  logic [9:0] expQ[$];

  always #2 clk = ~clk;

  setup_issuer #(.DEV_W(7), .TIMEOUT_CYC(TOUT)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .txValid(txValid), .txReady(txReady), .txByte(txByte), .txFirst(txFirst),
    .txLast(txLast), .rxValid(rxValid), .rxPid(rxPid), .irq(irq)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    txReady = !stallMode || (cyc % 3 == 0);
  end

  task automatic checkEq(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected bytes as the design offers them
  logic       heldPrev = 1'b0;
  logic [7:0] heldByte = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (heldPrev && txValid) checkEq("R5", {8'h0, txByte}, {8'h0, heldByte});
      if (txValid && txReady) begin
        if (expQ.size() == 0) begin
          checkEq("R3", 16'hDEAD, 16'h0);
        end else begin
          logic [9:0] e;
          e = expQ.pop_front();
          checkEq(((acceptCnt % 12) < 3) ? "R3" : "R4",
                  {6'h0, txFirst, txLast, txByte}, {6'h0, e});
        end
        acceptCnt++;
      end
      heldPrev = txValid && !txReady;
      heldByte = txByte;
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [15:0] v);
    regRdAddr = a;
    @(negedge clk);
    v = regRdData;
    @(posedge clk); #1;
  endtask

  // driver: pushes the expected byte stream for one request
  task automatic pushReq(input logic [15:0] r0, r1, r2, r3, input logic [6:0] a);
    expQ.push_back({2'b10, 8'h2D});
    expQ.push_back({2'b00, 1'b0, a});
    expQ.push_back({2'b01, 8'h00});
    expQ.push_back({2'b10, 8'hC3});
    expQ.push_back({2'b00, r0[7:0]});
    expQ.push_back({2'b00, r0[15:8]});
    expQ.push_back({2'b00, r1[7:0]});
    expQ.push_back({2'b00, r1[15:8]});
    expQ.push_back({2'b00, r2[7:0]});
    expQ.push_back({2'b00, r2[15:8]});
    expQ.push_back({2'b00, r3[7:0]});
    expQ.push_back({2'b01, r3[15:8]});
  endtask

  task automatic runReq(input logic [15:0] r0, r1, r2, r3, input logic [6:0] a,
                        input logic tog, input int d, input logic [7:0] pid,
                        input bit errWrite);
    logic [15:0] v;
    int target;
    wrReg(3'd0, r0); wrReg(3'd1, r1); wrReg(3'd2, r2); wrReg(3'd3, r3);
    wrReg(3'd4, {7'b0, tog, 1'b0, a});
    pushReq(r0, r1, r2, r3, a);
    target = acceptCnt + 12;
    wrReg(3'd5, 16'h0001);
    readReg(3'd5, v);
    checkEq("R2", v, 16'h0001);
    if (errWrite) wrReg(3'd0, 16'hFFFF);
    wait (acceptCnt >= target);
    @(posedge clk); #1;
    if (d >= 0) begin
      repeat (d) begin @(posedge clk); #1; end
      rxValid = 1'b1; rxPid = pid;
      @(posedge clk); #1;
      rxValid = 1'b0;
    end
    repeat (TOUT + 4) begin @(posedge clk); #1; end
    readReg(3'd5, v);
    checkEq("R2", v, 16'h0000);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    for (int k = 0; k < 7; k++) begin
      readReg(3'(k), v);
      checkEq("R1", v, 16'h0000);
    end
    checkEq("R1", {14'h0, txValid, irq}, 16'h0000);

    // ACK with locked-register write attempt
    runReq(16'h0680, 16'h0100, 16'h0000, 16'h0040, 7'h05, 1'b0, 3, 8'hD2, 1'b1);
    readReg(3'd6, v); checkEq("R6", v, 16'h0005);
    readReg(3'd0, v); checkEq("R9", v, 16'h0680);
    readReg(3'd4, v); checkEq("R6", v, 16'h0105);
    checkEq("R10", {15'h0, irq}, 16'h0001);
    wrReg(3'd6, 16'h0001);
    readReg(3'd6, v); checkEq("R10", v, 16'h0004);
    wrReg(3'd6, 16'h0004);
    readReg(3'd6, v); checkEq("R10", v, 16'h0000);
    checkEq("R10", {15'h0, irq}, 16'h0000);

    // NAK under backpressure, toggle preset to 1
    stallMode = 1;
    runReq(16'h0921, 16'h1234, 16'hABCD, 16'h0008, 7'h7F, 1'b1, 0, 8'h5A, 1'b0);
    stallMode = 0;
    readReg(3'd6, v); checkEq("R7", v, 16'h0002);
    readReg(3'd4, v); checkEq("R7", v, 16'h017F);
    wrReg(3'd6, 16'h0007);

    // no response: timeout
    runReq(16'h0500, 16'h0033, 16'h0000, 16'h0000, 7'h00, 1'b0, -1, 8'h00, 1'b0);
    readReg(3'd6, v); checkEq("R8", v, 16'h0002);
    readReg(3'd4, v); checkEq("R8", v, 16'h0000);
    wrReg(3'd6, 16'h0007);

    // ACK in last cycle of window
    runReq(16'h0102, 16'h0000, 16'h0081, 16'h0000, 7'h2A, 1'b0, TOUT - 1, 8'hD2, 1'b0);
    readReg(3'd6, v); checkEq("R8", v, 16'h0001);
    readReg(3'd4, v); checkEq("R8", v, 16'h012A);
    wrReg(3'd6, 16'h0007);

    // ACK one cycle late: timeout wins, late byte ignored
    runReq(16'h0880, 16'h0000, 16'h0000, 16'h0001, 7'h11, 1'b0, TOUT, 8'hD2, 1'b0);
    readReg(3'd6, v); checkEq("R11", v, 16'h0002);
    readReg(3'd4, v); checkEq("R11", v, 16'h0011);
    wrReg(3'd6, 16'h0007);

    // handshake while idle
    rxValid = 1'b1; rxPid = 8'hD2;
    @(posedge clk); #1;
    rxValid = 1'b0;
    readReg(3'd6, v); checkEq("R11", v, 16'h0000);
    readReg(3'd4, v); checkEq("R11", v, 16'h0011);

    checkEq("R4", 16'(expQ.size()), 16'h0000);
    report();
  end
endmodule